// File: doc/BRIEF.md
# ADC Result Accumulate-Average Unit

This unit sits behind an analog-to-digital converter. It post-processes the stream of conversion results under one of three computation modes. Each result arrives with a one-cycle valid strobe. The unit always keeps the latest raw word. In the two accumulating modes it also keeps a running sum and a sample counter, and it produces a filter word equal to the sum divided by a power of two.

In Accumulate mode the sum grows until software clears it. In Average mode the sum restarts by itself once the counter has passed a programmed repeat setting. The unit can raise an interrupt each time a full averaging window completes. A carry out of the sum sets a sticky overflow bit, and the counter saturates instead of wrapping.

Top module: `adc_accum_avg`

## Requirements
- R1: Mode code 0 is Basic, 1 is Accumulate, 2 is Average, and code 3 behaves as Basic. In Basic mode a valid result appears on `res_q` one cycle after the strobe, and `acc_q`, `cnt_q` and `flt_q` keep their values. `res_q` captures every valid result in every mode.
- R2: In Accumulate mode each valid result is added to `acc_q` and `cnt_q` rises by one, both visible one cycle after the strobe.
- R3: `cnt_q` saturates at 255 and never wraps to zero.
- R4: A carry out of bit 17 of the 18-bit sum sets `ovf_q`, and `acc_q` keeps the low 18 bits. `ovf_q` stays set until reset, and the software clear does not reset it.
- R5: `flt_q` equals the newly written `acc_q` shifted right by `shift_sel`. Shift codes 0 to 6 are used as given and code 7 acts as 6. `flt_q` is written in the same cycle as `acc_q` and is left alone in Basic mode.
- R6: `sw_clr` zeroes `acc_q`, `cnt_q` and `flt_q` on the next cycle. It wins over a valid result in the same cycle: that sample is not summed, though `res_q` still captures it.
- R7: In Average mode, a valid result that arrives while `cnt_q` is greater than or equal to `rpt_set` restarts the window: `acc_q` takes the sample itself and `cnt_q` becomes 1.
- R8: In Average mode with `irq_mode` equal to 7, a sample that brings `cnt_q` to exactly `rpt_set` sets `irq_q`. Other `irq_mode` values never set it. `irq_q` holds until `irq_clr` is pulsed, and a set in the same cycle wins over the clear.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | Conversion result valid strobe |
| res_data | input | 12 | Conversion result word |
| mode | input | 2 | Computation mode select |
| shift_sel | input | 3 | Filter right-shift amount |
| rpt_set | input | 8 | Average-mode repeat setting |
| sw_clr | input | 1 | Software clear of sum and counter |
| irq_mode | input | 3 | Interrupt mode, 7 means interrupt on each completed window |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| res_q | output | 12 | Latest raw result |
| acc_q | output | 18 | Running sum |
| cnt_q | output | 8 | Sample counter |
| flt_q | output | 18 | Shifted filter value |
| ovf_q | output | 1 | Sticky sum overflow |
| irq_q | output | 1 | Interrupt flag |

## Verification
The bound assertions check, on every cycle, the properties that stand alone: raw capture, Basic-mode hold, the counter step and its saturation, overflow stickiness, clear priority and interrupt hold. Only the bench scenarios can show the arithmetic values. These are the exact sums, the filter value under each shift code (including the clamp of 7), the overflow point after 65 full-scale samples, the Average-mode restart, and the interrupt firing at the repeat boundary. The bench computes these values from a model of its own.

// File: rtl/adcav_pkg.sv
package adcav_pkg;
  typedef enum logic [1:0] {
    MD_BASIC = 2'd0,
    MD_ACCUM = 2'd1,
    MD_AVG   = 2'd2,
    MD_RSVD  = 2'd3
  } mode_e;
endpackage

// File: rtl/adcav_accum.sv
module adcav_accum
  import adcav_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int ACC_W = 18,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [RES_W-1:0] data,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] rpt,
  input  logic             sw_clr,
  output logic [ACC_W-1:0] acc_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic [ACC_W-1:0] acc_nx,
  output logic             load,
  output logic             win_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nx;
  logic             ovf_nx;
  logic [ACC_W:0]   sum;
  logic             acc_en;
  logic             avg_en;
  logic             restart;

  assign acc_en  = vld && !sw_clr && (mode == MD_ACCUM);
  assign avg_en  = vld && !sw_clr && (mode == MD_AVG);
  assign restart = avg_en && (cnt_q >= rpt);
  assign sum     = {1'b0, acc_q} + {{(ACC_W+1-RES_W){1'b0}}, data};

  always_comb begin
    acc_nx   = acc_q;
    cnt_nx   = cnt_q;
    ovf_nx   = ovf_q;
    load     = 1'b0;
    win_done = 1'b0;
    if (sw_clr) begin
      acc_nx = '0;
      cnt_nx = '0;
    end else if (restart) begin
      acc_nx = {{(ACC_W-RES_W){1'b0}}, data};
      cnt_nx = CNT_ONE;
      load   = 1'b1;
    end else if (acc_en || avg_en) begin
      acc_nx = sum[ACC_W-1:0];
      ovf_nx = ovf_q | sum[ACC_W];
      cnt_nx = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
      load   = 1'b1;
    end
    win_done = avg_en && (cnt_nx == rpt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_nx;
      cnt_q <= cnt_nx;
      ovf_q <= ovf_nx;
    end
  end
endmodule

// File: rtl/adcav_shift.sv
module adcav_shift #(
  parameter int ACC_W  = 18,
  parameter int SH_W   = 3,
  parameter int MAX_SH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             zero,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [SH_W-1:0]  sh,
  output logic [ACC_W-1:0] flt_q
);
  localparam int N_SH = MAX_SH + 1;

  logic [ACC_W-1:0] cand [N_SH];
  logic [SH_W-1:0]  sh_eff;
  logic [ACC_W-1:0] flt_sel;
  logic [ACC_W-1:0] flt_nx;

  for (genvar k = 0; k < N_SH; k++) begin : g_cand
    assign cand[k] = acc_in >> k;
  end

  assign sh_eff = (int'(sh) > MAX_SH) ? SH_W'(MAX_SH) : sh;

  always_comb begin
    flt_sel = cand[0];
    for (int k = 1; k < N_SH; k++) begin
      if (int'(sh_eff) == k) flt_sel = cand[k];
    end
  end

  always_comb begin
    flt_nx = flt_q;
    if (zero)      flt_nx = '0;
    else if (load) flt_nx = flt_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= '0;
    else        flt_q <= flt_nx;
  end
endmodule

// File: rtl/adcav_irq.sv
module adcav_irq #(
  parameter int TMD_W      = 3,
  parameter int TMD_ALWAYS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_done,
  input  logic [TMD_W-1:0] tmd,
  input  logic             clr,
  output logic             irq_q
);
  logic set;
  logic irq_nx;

  assign set = win_done && (tmd == TMD_W'(TMD_ALWAYS));

  always_comb begin
    irq_nx = irq_q;
    if (set)      irq_nx = 1'b1;
    else if (clr) irq_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nx;
  end
endmodule

// File: rtl/adc_accum_avg.sv
module adc_accum_avg #(
  parameter int RES_W      = 12,
  parameter int ACC_W      = 18,
  parameter int CNT_W      = 8,
  parameter int SH_W       = 3,
  parameter int MAX_SH     = 6,
  parameter int TMD_W      = 3,
  parameter int TMD_ALWAYS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [RES_W-1:0] res_data,
  input  logic [1:0]       mode,
  input  logic [SH_W-1:0]  shift_sel,
  input  logic [CNT_W-1:0] rpt_set,
  input  logic             sw_clr,
  input  logic [TMD_W-1:0] irq_mode,
  input  logic             irq_clr,
  output logic [RES_W-1:0] res_q,
  output logic [ACC_W-1:0] acc_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [ACC_W-1:0] flt_q,
  output logic             ovf_q,
  output logic             irq_q
);
  logic [ACC_W-1:0] acc_nx;
  logic             load;
  logic             win_done;
  logic [RES_W-1:0] res_nx;

  assign res_nx = res_vld ? res_data : res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_nx;
  end

  adcav_accum #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld      (res_vld),
    .data     (res_data),
    .mode     (mode),
    .rpt      (rpt_set),
    .sw_clr   (sw_clr),
    .acc_q    (acc_q),
    .cnt_q    (cnt_q),
    .ovf_q    (ovf_q),
    .acc_nx   (acc_nx),
    .load     (load),
    .win_done (win_done)
  );

  adcav_shift #(.ACC_W(ACC_W), .SH_W(SH_W), .MAX_SH(MAX_SH)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .zero   (sw_clr),
    .acc_in (acc_nx),
    .sh     (shift_sel),
    .flt_q  (flt_q)
  );

  adcav_irq #(.TMD_W(TMD_W), .TMD_ALWAYS(TMD_ALWAYS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_done (win_done),
    .tmd      (irq_mode),
    .clr      (irq_clr),
    .irq_q    (irq_q)
  );
endmodule

// File: rtl/adcav_chk.sv
module adcav_chk #(
  parameter int RES_W = 12,
  parameter int ACC_W = 18,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_vld,
  input logic [RES_W-1:0] res_data,
  input logic [1:0]       mode,
  input logic             sw_clr,
  input logic             irq_clr,
  input logic [RES_W-1:0] res_q,
  input logic [ACC_W-1:0] acc_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [ACC_W-1:0] flt_q,
  input logic             ovf_q,
  input logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic basic_md;
  assign basic_md = (mode == 2'd0) || (mode == 2'd3);

  AST_RAW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> res_q == $past(res_data)); // R1

  AST_BASIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_md && !sw_clr) |=> ($stable(acc_q) && $stable(cnt_q) && $stable(flt_q))); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !sw_clr && mode == 2'd1 && cnt_q != CNT_MAX)
      |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !sw_clr && mode == 2'd1) |=> cnt_q == CNT_MAX); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> (acc_q == '0 && cnt_q == '0 && flt_q == '0)); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q); // R8
endmodule

bind adc_accum_avg adcav_chk #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_adc_accum_avg.sv
module tb_adc_accum_avg;
  logic        clk;
  logic        rst_n;
  logic        res_vld;
  logic [11:0] res_data;
  logic [1:0]  mode;
  logic [2:0]  shift_sel;
  logic [7:0]  rpt_set;
  logic        sw_clr;
  logic [2:0]  irq_mode;
  logic        irq_clr;
  logic [11:0] res_q;
  logic [17:0] acc_q;
  logic [7:0]  cnt_q;
  logic [17:0] flt_q;
  logic        ovf_q;
  logic        irq_q;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [11:0] res;
    logic [17:0] acc;
    logic [7:0]  cnt;
    logic [17:0] flt;
    logic        ovf;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];

  int m_acc, m_cnt, m_flt, m_res;
  bit m_ovf, m_irq;
  logic drv_any, sent_q;

  adc_accum_avg dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) sent_q <= drv_any;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sent_q === 1'b1 && rst_n) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(0, "SB", "empty queue", 0, 1);
      end else begin
        e = q.pop_front();
        chk(res_q == e.res && acc_q == e.acc && cnt_q == e.cnt &&
            flt_q == e.flt && ovf_q == e.ovf && irq_q == e.irq, e.tag,
            "res/acc/cnt/flt/ovf/irq", 0, 0);
        if (res_q != e.res) $display("  res actual=%0d expected=%0d", res_q, e.res);
        if (acc_q != e.acc) $display("  acc actual=%0d expected=%0d", acc_q, e.acc);
        if (cnt_q != e.cnt) $display("  cnt actual=%0d expected=%0d", cnt_q, e.cnt);
        if (flt_q != e.flt) $display("  flt actual=%0d expected=%0d", flt_q, e.flt);
        if (ovf_q != e.ovf) $display("  ovf actual=%0d expected=%0d", ovf_q, e.ovf);
        if (irq_q != e.irq) $display("  irq actual=%0d expected=%0d", irq_q, e.irq);
      end
    end
  end

  task automatic cfg(logic [1:0] md, logic [2:0] sh, logic [7:0] rp, logic [2:0] tm);
    @(negedge clk);
    res_vld = 0; sw_clr = 0; irq_clr = 0; drv_any = 0;
    mode = md; shift_sel = sh; rpt_set = rp; irq_mode = tm;
  endtask

  task automatic op(bit v, bit c, bit ic, logic [11:0] d, string tag);
    int s, sh, newcnt;
    bit set;
    exp_t e;
    @(negedge clk);
    res_vld = v; sw_clr = c; irq_clr = ic; res_data = d; drv_any = v | c | ic;
    set = 0;
    sh = (shift_sel > 6) ? 6 : int'(shift_sel);
    if (v) m_res = d;
    if (c) begin
      m_acc = 0; m_cnt = 0; m_flt = 0;
    end else if (v && mode == 2'd1) begin
      s = m_acc + d;
      if (s >= 262144) m_ovf = 1;
      m_acc = s % 262144;
      m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1;
      m_flt = m_acc >> sh;
    end else if (v && mode == 2'd2) begin
      if (m_cnt >= rpt_set) begin
        m_acc = d; newcnt = 1;
      end else begin
        s = m_acc + d;
        if (s >= 262144) m_ovf = 1;
        m_acc = s % 262144;
        newcnt = m_cnt + 1;
      end
      m_cnt = newcnt;
      m_flt = m_acc >> sh;
      if (irq_mode == 3'd7 && m_cnt == rpt_set) set = 1;
    end
    if (set) m_irq = 1;
    else if (ic) m_irq = 0;
    e.res = 12'(m_res); e.acc = 18'(m_acc); e.cnt = 8'(m_cnt);
    e.flt = 18'(m_flt); e.ovf = m_ovf; e.irq = m_irq; e.tag = tag;
    if (drv_any) q.push_back(e);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; res_vld = 0; res_data = 0; mode = 0; shift_sel = 0;
    rpt_set = 0; sw_clr = 0; irq_mode = 0; irq_clr = 0; drv_any = 0;
    m_acc = 0; m_cnt = 0; m_flt = 0; m_res = 0; m_ovf = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(res_q == 0 && acc_q == 0 && cnt_q == 0 && flt_q == 0 && ovf_q == 0 && irq_q == 0,
        "R9", "reset outputs nonzero", int'(acc_q) + int'(cnt_q), 0);

    // R1 Basic mode: raw captured, sum/count/filter untouched
    cfg(2'd0, 3'd0, 8'd0, 3'd7);
    op(1, 0, 0, 12'd1234, "R1");
    op(1, 0, 0, 12'd77, "R1");
    cfg(2'd3, 3'd0, 8'd0, 3'd7);
    op(1, 0, 0, 12'd4095, "R1");

    // R2 R5 Accumulate with shift 2
    cfg(2'd1, 3'd2, 8'd0, 3'd0);
    op(1, 0, 0, 12'd100, "R2");
    op(1, 0, 0, 12'd203, "R2");
    op(0, 0, 0, 12'd0, "R2");
    op(1, 0, 0, 12'd3001, "R5");
    cfg(2'd1, 3'd5, 8'd0, 3'd0);
    op(1, 0, 0, 12'd17, "R5");
    cfg(2'd1, 3'd7, 8'd0, 3'd0);
    op(1, 0, 0, 12'd640, "R5");
    cfg(2'd0, 3'd0, 8'd0, 3'd0);
    op(1, 0, 0, 12'd5, "R5");

    // R6 clear, and clear beats a simultaneous sample
    cfg(2'd1, 3'd0, 8'd0, 3'd0);
    op(0, 1, 0, 12'd0, "R6");
    op(1, 0, 0, 12'd9, "R6");
    op(1, 1, 0, 12'd55, "R6");

    // R3 counter saturation
    for (int i = 0; i < 260; i++) op(1, 0, 0, 12'd1, "R3");
    op(0, 1, 0, 12'd0, "R3");

    // R4 overflow after 65 full-scale samples, sticky through clear
    cfg(2'd1, 3'd1, 8'd0, 3'd0);
    for (int i = 0; i < 66; i++) op(1, 0, 0, 12'd4095, "R4");
    op(0, 1, 0, 12'd0, "R4");
    op(1, 0, 0, 12'd3, "R4");
    op(0, 1, 0, 12'd0, "R4");

    // R7 R8 Average mode window of 4, interrupt on completion
    cfg(2'd2, 3'd2, 8'd4, 3'd7);
    op(1, 0, 0, 12'd10, "R7");
    op(1, 0, 0, 12'd20, "R7");
    op(1, 0, 0, 12'd30, "R7");
    op(1, 0, 0, 12'd40, "R8");
    op(1, 0, 0, 12'd500, "R7");
    op(0, 0, 1, 12'd0, "R8");
    op(1, 0, 0, 12'd1, "R8");
    op(1, 0, 0, 12'd2, "R8");
    op(1, 1, 1, 12'd3, "R8");
    // completion coincides with clear request: set wins
    op(1, 0, 0, 12'd8, "R8");
    op(1, 0, 0, 12'd8, "R8");
    op(1, 0, 0, 12'd8, "R8");
    op(1, 0, 1, 12'd8, "R8");
    op(0, 0, 1, 12'd0, "R8");
    // other interrupt mode: window completes without interrupt
    cfg(2'd2, 3'd0, 8'd2, 3'd3);
    op(1, 0, 0, 12'd6, "R8");
    op(1, 0, 0, 12'd6, "R8");
    op(1, 0, 0, 12'd6, "R7");

    cfg(2'd0, 3'd0, 8'd0, 3'd0);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "SB", "leftover expected items", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule